// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control half of a successive-approximation analog-to-digital converter. The DAC, the comparator and the sample-and-hold sit outside it. When the block sees a start request, it pulses a strobe that tells the external sample-and-hold to capture the input. It then places a trial code on the DAC bus and reads the single comparator bit that comes back. It decides the code one bit at a time, starting at the most significant bit and ending at the least significant bit. When the last bit is decided, it publishes the code and pulses an end-of-conversion flag.

At start, a mode input selects full 10-bit resolution or reduced 8-bit resolution. In reduced mode the two lowest DAC bits stay at zero and the conversion is shorter.

A synchronous abort input drops any conversion in progress. It raises no completion flag.

Top module: `sar_ctrl`

## Requirements
- R1: After reset, busy, eoc and sh_strobe are 0, and dac_code and result are all zeros.
- R2: A start sampled while idle raises sh_strobe for exactly one cycle, beginning at that edge. At the next edge, dac_code becomes a code with only its top bit set (512 at the default width).
- R3: cmp_in high means the held input is at or above the DAC level. The bit under test is kept when the registered comparator value is 1 and cleared when it is 0, and the next lower bit is then set as the new trial. The result is the largest code at the chosen resolution that does not exceed the input. For example, an input at 0.6 of full scale (code 614) yields a result whose top five bits are 10011.
- R4: The comparator is registered every cycle. Each bit takes two clocks: one with the trial code applied and one that decides using the sampled value. eoc is a one-cycle pulse visible 2N+2 clock edges after the edge that samples start, counting that edge as the first, where N is the resolution.
- R5: res_lo is captured at start. A value of 1 selects 8 bits, which gives N=8, and keeps dac_code bits 1:0 and result bits 1:0 at 0. A value of 0 selects 10 bits. Changing res_lo during a conversion has no effect on that conversion.
- R6: result changes only at the edge that raises eoc and then holds its value until the next completed conversion.
- R7: A start asserted while busy is ignored: the result and the timing of the running conversion are unchanged.
- R8: abort returns the block to idle at the next edge, with busy 0, eoc never raised and result unchanged. abort takes priority over start.
- R9: busy is 1 from the edge that samples start until the edge that raises eoc, and busy is 0 while eoc is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion when idle |
| abort | input | 1 | Cancel the running conversion |
| res_lo | input | 1 | 1 selects 8-bit, 0 selects 10-bit |
| cmp_in | input | 1 | Comparator: input at or above DAC level |
| sh_strobe | output | 1 | Sample-and-hold capture strobe |
| dac_code | output | 10 | Trial code driven to the DAC |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| result | output | 10 | Last completed conversion code |

## Verification
The bench builds the block with its defaults: a 10-bit bus and an 8-bit reduced mode. At that size an ideal comparator that checks a stored code against dac_code lets every one of the 1024 input codes be converted in both modes. This covers every keep/clear path and both end points. Along the way it checks the latency and the zero low bits on each run. Interleaved runs insert stray starts and mode flips mid-conversion, and separate cases exercise abort.

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int DW     = 10,
  parameter int LOW_DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic          res_lo,
  input  logic          cmp_in,
  output logic          sh_strobe,
  output logic [DW-1:0] dac_code,
  output logic          busy,
  output logic          eoc,
  output logic [DW-1:0] result
);
  localparam int DROP = DW - LOW_DW;
  localparam logic [DW-1:0] TOP = {1'b1, {(DW-1){1'b0}}};

  typedef enum logic [1:0] {IDLE, SAMPLE, APPLY, DECIDE} st_t;

  st_t st;
  logic [DW-1:0] trial, probe, kept;
  logic cmp_q, mode_q, last_bit;

  assign kept      = cmp_q ? trial : (trial & ~probe);
  assign last_bit  = mode_q ? probe[DROP] : probe[0];
  assign sh_strobe = (st == SAMPLE);
  assign busy      = (st != IDLE);
  assign dac_code  = trial;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      trial  <= '0;
      probe  <= '0;
      cmp_q  <= 1'b0;
      mode_q <= 1'b0;
      eoc    <= 1'b0;
      result <= '0;
    end else begin
      eoc   <= 1'b0;
      cmp_q <= cmp_in;
      if (abort) begin
        st    <= IDLE;
        trial <= '0;
        probe <= '0;
      end else begin
        case (st)
          IDLE: if (start) begin
            st     <= SAMPLE;
            mode_q <= res_lo;
          end
          SAMPLE: begin
            st    <= APPLY;
            trial <= TOP;
            probe <= TOP;
          end
          APPLY: st <= DECIDE;
          DECIDE: begin
            if (last_bit) begin
              result <= kept;
              trial  <= '0;
              probe  <= '0;
              eoc    <= 1'b1;
              st     <= IDLE;
            end else begin
              trial <= kept | (probe >> 1);
              probe <= probe >> 1;
              st    <= APPLY;
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  // R4
  eoc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);

  // R2
  sh_first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_strobe && !abort) |=> (!sh_strobe && dac_code == TOP));

  // R5
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q) |-> (dac_code[DROP-1:0] == '0));

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !eoc && $stable(result)));

  // R9
  eoc_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> !busy);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> $stable(result));
endmodule

// File: tb/sar_ctrl_tb.sv
`timescale 1ns/1ps
module sar_ctrl_tb;
  logic clk = 0, rst_n = 0, start = 0, abort = 0, res_lo = 0;
  logic [9:0] vin = '0;
  logic sh_strobe, busy, eoc, cmp_in;
  logic [9:0] dac_code, result;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;
  assign cmp_in = (vin >= dac_code);

  sar_ctrl u_dut (.clk, .rst_n, .start, .abort, .res_lo, .cmp_in,
                  .sh_strobe, .dac_code, .busy, .eoc, .result);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic convert(input int v, input bit lo, input bit stray);
    int n, exp, lowseen, shcnt;
    @(negedge clk); vin = v; res_lo = lo; start = 1;
    @(negedge clk); start = 0; n = 1; lowseen = 0; shcnt = 0;
    chk(sh_strobe === 1'b1, "R2 strobe", sh_strobe, 1);
    while (!eoc && n < 40) begin
      if (sh_strobe) shcnt++;
      if (n == 2) chk(dac_code === 10'd512, "R2 first trial", dac_code, 512);
      if (lo && dac_code[1:0] != 0) lowseen = 1;
      if (n >= 1) chk(busy === 1'b1, "R9 busy", busy, 1);
      if (stray && n == 5) begin start = 1; res_lo = !lo; end
      else start = 0;
      @(negedge clk); n++;
    end
    start = 0;
    exp = lo ? (v & ~3) : v;
    chk(shcnt == 1, "R2 strobe width", shcnt, 1);
    chk(n == (lo ? 18 : 22), "R4 latency", n, lo ? 18 : 22);
    chk(result === exp[9:0], "R3 result", result, exp);
    chk(lowseen == 0, "R5 low dac bits", lowseen, 0);
    chk(busy === 1'b0, "R9 idle at eoc", busy, 0);
    @(negedge clk);
    chk(eoc === 1'b0, "R4 eoc one cycle", eoc, 0);
    chk(result === exp[9:0], "R6 hold", result, exp);
    if (stray) begin
      @(negedge clk);
      chk(busy === 1'b0, "R7 stray start ignored", busy, 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seen, prev;
    repeat (3) @(negedge clk);
    chk(busy === 0 && eoc === 0 && sh_strobe === 0, "R1 flags", {busy, eoc, sh_strobe}, 0);
    chk(dac_code === 0 && result === 0, "R1 codes", dac_code, 0);
    rst_n = 1;
    convert(614, 0, 0);
    chk(result[9:5] === 5'b10011, "R3 0.6 full scale", result[9:5], 19);
    for (int v = 0; v < 1024; v++) convert(v, 0, (v % 7) == 3);
    for (int v = 0; v < 1024; v++) convert(v, 1, (v % 5) == 2);
    convert(1023, 1, 1);
    // R8 abort mid-conversion
    prev = result;
    @(negedge clk); vin = 300; res_lo = 0; start = 1;
    @(negedge clk); start = 0;
    repeat (6) @(negedge clk);
    abort = 1;
    @(negedge clk); abort = 0;
    chk(busy === 1'b0, "R8 abort idle", busy, 0);
    seen = 0;
    repeat (30) begin @(negedge clk); if (eoc) seen = 1; end
    chk(seen == 0, "R8 no eoc", seen, 0);
    chk(result === prev[9:0], "R8 result kept", result, prev);
    // R8 abort over start
    start = 1; abort = 1;
    @(negedge clk); start = 0; abort = 0;
    chk(busy === 1'b0 && sh_strobe === 1'b0, "R8 abort priority", busy, 0);
    convert(300, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule